// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target front end that lets a bus master reach a register file organised as four channels of sixteen byte-wide registers. It watches the synchronised SCL and SDA lines for START, repeated START and STOP, compares the seven-bit address in the first byte of each transfer with an address picked by a four-bit strap code, and acknowledges on a match. SDA is driven through an open-drain enable: `sda_oe` high pulls the line low.

In a write transfer the byte after the address is a subaddress. It selects a channel and a register, and every following data byte is written to that one register until STOP. To read, the master sets the subaddress with a write, then issues a repeated START with the read bit set. The block returns bytes from the same register for as long as the master acknowledges. A single-cycle read strobe goes out one system clock before each byte is captured, so a register with side effects on read, such as a FIFO pop, fires once per byte.

Top module: `i2c_regport`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_re` are low and `reg_chan`/`reg_idx` are zero.
- R2: The first byte after a START carries the target address in bits 7:1 and the direction in bit 0 (0 = master writes, 1 = master reads). It is acknowledged only when bits 7:1 equal 0x48 + `strap_code`, which is the 8-bit form 0x90 + 2×code. The code is {high digit, low digit}, and each two-bit digit is 0 for a supply strap, 1 for ground, 2 for SCL and 3 for SDA.
- R3: After an address that does not match, the block never pulls SDA low and issues no register strobe until the next START.
- R4: In a write transfer the second byte is the subaddress and is always acknowledged. Bits 6:3 go to `reg_idx` and bits 2:1 go to `reg_chan`. Bits 7 and 0 have no effect.
- R5: Each data byte after the subaddress is acknowledged and written to the selected register. The byte is received MSB first and appears on `reg_wdata` with a one-cycle `reg_we` pulse.
- R6: After a repeated START (or a fresh START) with the read bit set, the block returns the register chosen by the last subaddress, MSB first. Each byte is preceded by exactly one single-cycle `reg_re` pulse, and `reg_rdata` is captured at the end of that pulse's cycle.
- R7: While reading, a master ACK (SDA low on the ninth clock) starts the next byte. A NACK makes the block release SDA and stop strobing until the next START or STOP.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Clocked bytes that arrive after it without a START are ignored.
- R9: The block changes `sda_oe` only while SCL is low, and it holds its acknowledge low throughout the ninth SCL clock of each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_code | input | 4 | Address strap code, {high digit, low digit} |
| reg_chan | output | 2 | Channel selected by the subaddress |
| reg_idx | output | 4 | Register index selected by the subaddress |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the selected register |
| reg_re | output | 1 | Single-cycle read strobe, one clock before capture |

## Verification
The assertions assume that each SCL high and low phase lasts several system clocks, longer than the synchroniser delay plus the two registers that follow it. They also assume that the master moves SDA only while SCL is low, except for START and STOP, and that it never tries a STOP while the block holds SDA low. The stimulus keeps to these conditions. It uses sixteen-clock half periods of SCL, changes SDA two clocks after each SCL fall, and only issues STOP or repeated START after an acknowledge slot that the block has released.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_SUB,
    ST_WDATA,
    ST_WACK,
    ST_RLOAD,
    ST_TX,
    ST_MACK,
    ST_MACKD,
    ST_HOLD
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '1;
          last  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], raw[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign synced[g] = chain[STAGES-1];
      assign prev[g]   = last;
    end
  endgenerate

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] & prev[0];
  assign start_p  = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_p   = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_addr_map.sv
module i2c_addr_map #(
  parameter logic [6:0] BASE_ADDR = 7'h48,
  parameter int         CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [6:0]        addr
);
  always_ff @(posedge clk) begin
    if (rst) addr <= BASE_ADDR;
    else     addr <= BASE_ADDR + 7'(code);
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regport_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [6:0]        my_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [CHAN_W-1:0] reg_chan,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re
);
  localparam logic [BITCNT_W-1:0] RX_DONE = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] TX_LAST = BITCNT_W'(BYTE_W - 1);
  localparam int CH_LO = 1;
  localparam int CH_HI = CHAN_W;
  localparam int IX_LO = CHAN_W + 1;
  localparam int IX_HI = CHAN_W + IDX_W;

  tgt_state_e          st_q;
  logic [BYTE_W-1:0]   sh_q;
  logic [BITCNT_W-1:0] cnt_q;
  logic                rw_q;
  logic                oe_q;
  logic [CHAN_W-1:0]   chan_q;
  logic [IDX_W-1:0]    idx_q;
  logic [BYTE_W-1:0]   wd_q;
  logic                we_q;
  logic                re_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      chan_q <= '0;
      idx_q  <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (start_p) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_p) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && cnt_q != RX_DONE) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == RX_DONE) begin
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == my_addr) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                  st_q <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_SUB) begin
                oe_q   <= 1'b1;
                chan_q <= sh_q[CH_HI:CH_LO];
                idx_q  <= sh_q[IX_HI:IX_LO];
                st_q   <= ST_WACK;
              end else begin
                oe_q <= 1'b1;
                wd_q <= sh_q;
                we_q <= 1'b1;
                st_q <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              if (rw_q) begin
                re_q <= 1'b1;
                st_q <= ST_RLOAD;
              end else begin
                st_q <= ST_SUB;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_WDATA;
            end
          end
          ST_RLOAD: begin
            sh_q  <= reg_rdata;
            oe_q  <= ~reg_rdata[BYTE_W-1];
            cnt_q <= '0;
            st_q  <= ST_TX;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == TX_LAST) begin
                oe_q <= 1'b0;
                st_q <= ST_MACK;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) st_q <= sda_s ? ST_HOLD : ST_MACKD;
          end
          ST_MACKD: begin
            if (scl_fall) begin
              re_q <= 1'b1;
              st_q <= ST_RLOAD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_chan  = chan_q;
  assign reg_idx   = idx_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> !scl_s);

  // R2
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_q) && $past(st_q) == ST_ADDR) |-> $past(sh_q[7:1]) == my_addr);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (st_q == ST_IDLE && !oe_q));

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);

  // R5
  we_write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !rw_q);

  // R6
  re_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    re_q |=> (!re_q && !we_q));

  // R6
  re_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    re_q |-> !scl_s);
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h48,
  parameter int         STRAP_W     = 4,
  parameter int         CHAN_W      = 2,
  parameter int         IDX_W       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_code,
  output logic [CHAN_W-1:0]  reg_chan,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [BYTE_W-1:0]  reg_rdata,
  output logic               reg_re
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [6:0] my_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_addr_map #(.BASE_ADDR(BASE_ADDR), .CODE_W(STRAP_W)) u_addr (
    .clk(clk), .rst(rst), .code(strap_code), .addr(my_addr)
  );

  i2c_target_fsm #(.CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .my_addr(my_addr), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
    .reg_chan(reg_chan), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re)
  );
endmodule

// File: tb/i2c_regport_tb.sv
`timescale 1ns/1ps
module i2c_regport_tb;
  localparam int H = 16;
  localparam int NV = 9;
  // {strap code, address byte, expected ack}
  localparam logic [12:0] VECS [NV] = '{
    {4'd0,  8'h90, 1'b1}, {4'd0,  8'h92, 1'b0}, {4'd5,  8'h9A, 1'b1},
    {4'd9,  8'hA2, 1'b1}, {4'd3,  8'h96, 1'b1}, {4'd3,  8'h98, 1'b0},
    {4'd12, 8'hA8, 1'b1}, {4'd15, 8'hAE, 1'b1}, {4'd15, 8'hAC, 1'b0}
  };

  logic       clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'd0;
  logic       sda_oe, reg_we, reg_re;
  logic [1:0] reg_chan;
  logic [3:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_bus;

  int checks = 0, fails = 0, wr_cnt = 0, pops = 0, viol = 0;
  logic [7:0] regs [4][16];
  logic [7:0] log_d [32];
  logic [1:0] log_c [32];
  logic [3:0] log_i [32];
  logic       oe_prev = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_chan][reg_idx] + 8'(pops);

  i2c_regport u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_code(strap), .reg_chan(reg_chan), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 16; i++) regs[c][i] <= 8'(8'h40 + c * 16 + i);
      wr_cnt <= 0;
      pops   <= 0;
    end else begin
      if (reg_we) begin
        regs[reg_chan][reg_idx] <= reg_wdata;
        if (wr_cnt < 32) begin
          log_d[wr_cnt] <= reg_wdata;
          log_c[wr_cnt] <= reg_chan;
          log_i[wr_cnt] <= reg_idx;
        end
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_re) pops <= pops + 1;
      if (sda_oe != oe_prev && scl_m) viol <= viol + 1;
    end
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(H);
      scl_m = 1'b1; wclk(H);
      scl_m = 1'b0; wclk(2);
    end
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H / 2);
    acked = ~sda_bus; wclk(H / 2);
    scl_m = 1'b0; wclk(2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(H);
      scl_m = 1'b1; wclk(H / 2);
      b[i] = sda_bus; wclk(H / 2);
      scl_m = 1'b0; wclk(2);
    end
    sda_m = ~give_ack; wclk(H);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(2);
    sda_m = 1'b1;
  endtask

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         w0, p0;
    wclk(10);
    rst = 1'b0;
    wclk(4);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(reg_we == 1'b0 && reg_re == 1'b0, "R1 strobes", {reg_we, reg_re}, 0);
    check(reg_chan == 2'd0 && reg_idx == 4'd0, "R1 select", {reg_chan, reg_idx}, 0);

    // R2 / R3 address table
    for (int v = 0; v < NV; v++) begin
      strap = VECS[v][12:9];
      wclk(4);
      bus_start();
      send_byte(VECS[v][8:1], ack);
      check(ack == VECS[v][0], "R2 address ack", ack, VECS[v][0]);
      if (!VECS[v][0]) begin
        w0 = wr_cnt;
        send_byte(8'h00, ack);
        check(!ack, "R3 silent after mismatch", ack, 0);
        check(wr_cnt == w0, "R3 no write after mismatch", wr_cnt, w0);
      end
      bus_stop();
    end

    // R4 / R5 write with ignored subaddress bits 7 and 0 set
    strap = 4'd5;
    wclk(4);
    bus_start();
    send_byte(8'h9A, ack);
    check(ack, "R2 strap 5 ack", ack, 1);
    send_byte(8'hD5, ack);
    check(ack, "R4 subaddress ack", ack, 1);
    check(reg_idx == 4'd10 && reg_chan == 2'd2, "R4 fields", {reg_chan, reg_idx}, {2'd2, 4'd10});
    w0 = wr_cnt;
    send_byte(8'h3C, ack);
    check(ack, "R5 data ack 1", ack, 1);
    send_byte(8'hC3, ack);
    check(ack, "R5 data ack 2", ack, 1);
    bus_stop();
    check(wr_cnt == w0 + 2, "R5 write count", wr_cnt, w0 + 2);
    check(log_d[w0] == 8'h3C && log_d[w0 + 1] == 8'hC3, "R5 write data",
          {log_d[w0], log_d[w0 + 1]}, 16'h3CC3);
    check(log_c[w0] == 2'd2 && log_i[w0 + 1] == 4'd10, "R5 same register",
          {log_c[w0], log_i[w0 + 1]}, {2'd2, 4'd10});

    // R6 / R7 combined format: set subaddress, repeated START, read three
    bus_start();
    send_byte(8'h9A, ack);
    send_byte(8'h28, ack);
    check(ack && reg_idx == 4'd5 && reg_chan == 2'd0, "R4 subaddress 0x28",
          {reg_chan, reg_idx}, {2'd0, 4'd5});
    p0 = pops;
    bus_rstart();
    send_byte(8'h9B, ack);
    check(ack, "R6 read address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, rb);
      check(rb == 8'(8'h45 + p0 + k), "R6 read byte", rb, 8'(8'h45 + p0 + k));
    end
    wclk(H);
    check(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    check(pops == p0 + 3, "R7 one strobe per byte", pops, p0 + 3);
    bus_stop();

    // R6 read back the register written above
    bus_start();
    send_byte(8'h9A, ack);
    send_byte(8'h54, ack);
    p0 = pops;
    bus_rstart();
    send_byte(8'h9B, ack);
    recv_byte(1'b0, rb);
    check(rb == 8'(8'hC3 + p0), "R6 read written register", rb, 8'(8'hC3 + p0));
    bus_stop();

    // R8 bytes after STOP with no START are ignored
    w0 = wr_cnt;
    send_byte(8'h9A, ack);
    check(!ack, "R8 idle after STOP", ack, 0);
    send_byte(8'h11, ack);
    check(!ack && wr_cnt == w0, "R8 no write after STOP", wr_cnt, w0);
    wclk(H);
    bus_stop();

    // R6 fresh START read uses the last subaddress
    p0 = pops;
    bus_start();
    send_byte(8'h9B, ack);
    recv_byte(1'b0, rb);
    check(rb == 8'(8'hC3 + p0), "R6 read without new subaddress", rb, 8'(8'hC3 + p0));
    bus_stop();

    // R9 SDA enable only moved while SCL low
    check(viol == 0, "R9 sda_oe change with SCL high", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule